// File: doc/BRIEF.md
# Boot Status Blink-Code LED Driver

This block drives a single indicator LED so that an operator can read, from the blink rhythm alone, which boot source is selected and whether that selection came from a hardware strap or from software. The 2-bit boot mode and the one-bit source flag form a 3-bit status code. Six of the eight codes are shown as a repeating frame of slots: a run of lit slots at the start, then dark slots to the end of the frame. The remaining two codes are shown as a steady dark LED and a steady lit LED.

Each slot lasts `SLOT_CYCLES` clock cycles. The default is 62,500,000, which is 250 ms at 250 MHz. A lit slot is on for its first half and off for its second half, so adjacent lit slots appear as separate pulses. When the status code changes, the frame restarts from its first slot. The status inputs are expected to be static or synchronous to `clk_i`.

Top module: `boot_led_top`

## Requirements
- R1: While `rst_ni` is low, `led_o` is 0. After release, the frame starts at slot 0, so the first output of any non-steady code is a lit first half when the lit count is 1 or more.
- R2: A frame is `FRAME_SLOTS` slots (default 8). The lit slots occupy slots 0 to N-1 and every later slot is dark. The frame repeats without a gap for as long as the code is unchanged.
- R3: A lit slot drives `led_o` high for the first `SLOT_CYCLES/2` cycles and low for the remaining cycles. A dark slot keeps `led_o` low for all `SLOT_CYCLES` cycles.
- R4: Code hardware/JTAG (`sw_sel_i`=0, `boot_mode_i`=0) holds `led_o` low permanently.
- R5: With hardware selection, QSPI (`boot_mode_i`=1) gives N=1, eMMC (`boot_mode_i`=2) gives N=2 and SD (`boot_mode_i`=3) gives N=3.
- R6: With software selection (`sw_sel_i`=1), JTAG gives N=4 and QSPI gives N=5.
- R7: Software/eMMC gives N=`FRAME_SLOTS`, which is one on/off pulse in every slot (8 pulses per frame by default).
- R8: Software/SD holds `led_o` high permanently.
- R9: Any change of {`sw_sel_i`, `boot_mode_i`} restarts the frame at slot 0.
  - The input change is registered at the next clock edge, E0.
  - The LED value taken after edge E(k+1) reflects frame position k of the new code, counted in cycles from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| boot_mode_i | input | 2 | Boot source: 0 JTAG, 1 QSPI, 2 eMMC, 3 SD |
| sw_sel_i | input | 1 | 1 when the boot source was chosen by software, 0 when chosen by hardware |
| led_o | output | 1 | LED drive, active high |

## Verification
Some properties are checked by assertions on every cycle:
- A dark slot keeps the LED off.
- The second half of every slot is off, except for the steady-on code.
- The two steady codes never toggle.
- A restart always returns the slot counter to 0.
- The slot counter holds its value between prescaler ticks.

The bench's scenarios are needed for the rest:
- The exact number of lit slots for each of the eight codes.
- The cycle-exact phase after a code change or a reset in mid-frame.
- The count of distinct pulses in the all-lit frame.

// File: rtl/boot_led_pkg.sv
package boot_led_pkg;

  typedef enum logic [1:0] {
    BM_JTAG = 2'd0,
    BM_QSPI = 2'd1,
    BM_EMMC = 2'd2,
    BM_SD   = 2'd3
  } boot_mode_e;

  typedef struct packed {
    logic       sw;
    boot_mode_e mode;
  } led_code_t;

  // number of lit slots in a frame for a given status code
  function automatic int unsigned lit_slots(led_code_t c, int unsigned frame);
    int unsigned n;
    unique case ({c.sw, c.mode})
      {1'b0, BM_JTAG}: n = 0;
      {1'b0, BM_QSPI}: n = 1;
      {1'b0, BM_EMMC}: n = 2;
      {1'b0, BM_SD}:   n = 3;
      {1'b1, BM_JTAG}: n = 4;
      {1'b1, BM_QSPI}: n = 5;
      default:         n = frame;
    endcase
    return n;
  endfunction

  function automatic logic is_steady_on(led_code_t c);
    return c.sw && (c.mode == BM_SD);
  endfunction

endpackage

// File: rtl/blink_prescaler.sv
module blink_prescaler #(
  parameter int unsigned SLOT_CYCLES = 62_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o,
  output logic first_half_o
);
  localparam int unsigned CW   = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) : 1;
  localparam int unsigned HALF = SLOT_CYCLES / 2;

  logic [CW-1:0] cnt_q;

  assign tick_o       = (cnt_q == CW'(SLOT_CYCLES - 1));
  assign first_half_o = (cnt_q < CW'(HALF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + CW'(1);
  end

  AST_NEW_SLOT_LIT_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o || restart_i) |=> first_half_o); // R3

endmodule

// File: rtl/blink_slot_ctr.sv
module blink_slot_ctr #(
  parameter int unsigned FRAME_SLOTS = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           restart_i,
  input  logic                           tick_i,
  output logic [$clog2(FRAME_SLOTS)-1:0] slot_o
);
  localparam int unsigned SW = $clog2(FRAME_SLOTS);

  logic [SW-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        slot_q <= '0;
    else if (restart_i) slot_q <= '0;
    else if (tick_i)    slot_q <= (slot_q == SW'(FRAME_SLOTS - 1)) ? '0 : slot_q + SW'(1);
  end

  assign slot_o = slot_q;

  AST_RESTART_SLOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (slot_o == '0)); // R9

  AST_SLOT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i) |=> $stable(slot_o)); // R2

endmodule

// File: rtl/blink_pattern.sv
module blink_pattern
  import boot_led_pkg::*;
#(
  parameter int unsigned FRAME_SLOTS = 8
) (
  input  led_code_t                      code_i,
  input  logic [$clog2(FRAME_SLOTS)-1:0] slot_i,
  input  logic                           first_half_i,
  output logic                           led_o,
  output logic                           dark_slot_o
);
  localparam int unsigned LW = $clog2(FRAME_SLOTS + 1);

  logic [LW-1:0] lit_n;
  logic [LW-1:0] slot_ext;

  always_comb begin
    lit_n       = LW'(lit_slots(code_i, FRAME_SLOTS));
    slot_ext    = LW'(slot_i);
    dark_slot_o = (slot_ext >= lit_n);
    if (is_steady_on(code_i)) led_o = 1'b1;
    else                      led_o = !dark_slot_o && first_half_i;
  end

endmodule

// File: rtl/boot_led_top.sv
module boot_led_top
  import boot_led_pkg::*;
#(
  parameter int unsigned SLOT_CYCLES = 62_500_000,
  parameter int unsigned FRAME_SLOTS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] boot_mode_i,
  input  logic       sw_sel_i,
  output logic       led_o
);
  localparam int unsigned SW = $clog2(FRAME_SLOTS);

  led_code_t     code_d, code_q;
  logic          chg;
  logic          tick;
  logic          first_half;
  logic [SW-1:0] slot;
  logic          led_d;
  logic          dark_slot;
  logic          led_q;

  assign code_d = '{sw: sw_sel_i, mode: boot_mode_e'(boot_mode_i)};
  assign chg    = (code_d != code_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '{sw: 1'b0, mode: BM_JTAG};
    else         code_q <= code_d;
  end

  blink_prescaler #(.SLOT_CYCLES(SLOT_CYCLES)) u_presc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (chg),
    .tick_o      (tick),
    .first_half_o(first_half)
  );

  blink_slot_ctr #(.FRAME_SLOTS(FRAME_SLOTS)) u_slot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(chg),
    .tick_i   (tick),
    .slot_o   (slot)
  );

  blink_pattern #(.FRAME_SLOTS(FRAME_SLOTS)) u_pat (
    .code_i      (code_q),
    .slot_i      (slot),
    .first_half_i(first_half),
    .led_o       (led_d),
    .dark_slot_o (dark_slot)
  );

  // registered output, glitch free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) led_q <= 1'b0;
    else         led_q <= led_d;
  end

  assign led_o = led_q;

  AST_STEADY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q == 3'b000) |=> !led_o); // R4

  AST_STEADY_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q == 3'b111) |=> led_o); // R8

  AST_DARK_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dark_slot && code_q != 3'b111) |=> !led_o); // R2

  AST_SECOND_HALF_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!first_half && code_q != 3'b111) |=> !led_o); // R3

  AST_LIT_FIRST_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_half && !dark_slot) |=> led_o); // R3

endmodule

// File: tb/tb_boot_led_top.sv
`timescale 1ns/1ps
module tb_boot_led_top;
  localparam int SLOT  = 8;
  localparam int FRAME = 8;
  localparam int NV    = 8;

  // {steady_on, sw, mode[1:0], lit[3:0]}
  localparam logic [7:0] VEC [NV] = '{
    {1'b0, 1'b0, 2'd0, 4'd0},  // R4 hw JTAG off
    {1'b0, 1'b0, 2'd1, 4'd1},  // R5 hw QSPI
    {1'b0, 1'b0, 2'd2, 4'd2},  // R5 hw eMMC
    {1'b0, 1'b0, 2'd3, 4'd3},  // R5 hw SD
    {1'b0, 1'b1, 2'd0, 4'd4},  // R6 sw JTAG
    {1'b0, 1'b1, 2'd1, 4'd5},  // R6 sw QSPI
    {1'b0, 1'b1, 2'd2, 4'd8},  // R7 sw eMMC
    {1'b1, 1'b1, 2'd3, 4'd0}   // R8 sw SD on
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] boot_mode_i = 2'd0;
  logic       sw_sel_i = 1'b0;
  logic       led_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  boot_led_top #(.SLOT_CYCLES(SLOT), .FRAME_SLOTS(FRAME)) dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boot_mode_i(boot_mode_i),
    .sw_sel_i   (sw_sel_i),
    .led_o      (led_o)
  );

  function automatic string vec_tag(int i);
    case (i)
      0: return "R4";
      1, 2, 3: return "R5";
      4, 5: return "R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic exp_led(logic on, int lit, int k);
    int slot_n, ph;
    slot_n = (k / SLOT) % FRAME;
    ph = k % SLOT;
    if (on) return 1'b1;
    return (slot_n < lit) && (ph < SLOT / 2);
  endfunction

  task automatic check_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s led=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // new code registered at the coming edge E0; led after E(k+1) = pos k
  task automatic check_wave(string tag, logic on, int lit);
    int bad = 0;
    int first_k = -1;
    logic first_act = 1'b0;
    @(posedge clk_i);
    for (int k = 0; k < 2 * FRAME * SLOT; k++) begin
      @(posedge clk_i);
      #1;
      if (led_o !== exp_led(on, lit, k)) begin
        if (first_k < 0) begin
          first_k = k;
          first_act = led_o;
        end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      failures++;
      $display("FAIL %s at pos %0d led=%0b expected=%0b (%0d mismatches)",
               tag, first_k, first_act, exp_led(on, lit, first_k), bad);
    end
  endtask

  task automatic apply(logic sw, logic [1:0] mode);
    @(negedge clk_i);
    sw_sel_i = sw;
    boot_mode_i = mode;
  endtask

  initial begin
    int pulses;
    logic prev;

    // R1: reset dark even with steady-on code present
    sw_sel_i = 1'b1;
    boot_mode_i = 2'd3;
    repeat (3) @(posedge clk_i);
    #1 check_bit("R1 in reset", led_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    check_wave("R1/R8 after release", 1'b1, 0);

    // table walk, every entry differs from the previous code (R9)
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][6], VEC[i][5:4]);
      check_wave(vec_tag(i), VEC[i][7], int'(VEC[i][3:0]));
    end

    // R9: change in mid-frame restarts at slot 0
    apply(1'b1, 2'd1);
    repeat (21) @(posedge clk_i);
    apply(1'b0, 2'd2);
    check_wave("R9 mid-frame change", 1'b0, 2);

    // R7: pulse count in one all-lit frame
    apply(1'b1, 2'd2);
    @(posedge clk_i);
    @(posedge clk_i);
    #1;
    prev = 1'b0;
    pulses = (led_o === 1'b1) ? 1 : 0;
    prev = led_o;
    for (int k = 1; k < FRAME * SLOT; k++) begin
      @(posedge clk_i);
      #1;
      if (led_o === 1'b1 && prev === 1'b0) pulses++;
      prev = led_o;
    end
    checks++;
    if (pulses != FRAME) begin
      failures++;
      $display("FAIL R7 pulses=%0d expected=%0d", pulses, FRAME);
    end

    // R1: reset while lit clears frame
    apply(1'b0, 2'd3);
    @(posedge clk_i);
    @(posedge clk_i);
    @(posedge clk_i);
    #1 check_bit("R5 lit before reset", led_o, 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 check_bit("R1 async reset", led_o, 1'b0);
    repeat (3) @(posedge clk_i);
    #1 check_bit("R1 held reset", led_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    check_wave("R1 restart after reset", 1'b0, 3);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule